// File: doc/BRIEF.md
# Tooth/Gap Alternation Health Monitor

This block supervises a one-bit sensor that reads 1 when a tooth passes and 0 when a gap passes. A healthy wheel gives teeth and gaps in strict turn. The block samples the sensor on each rising clock edge where the sample enable is high. It is a four-state Moore machine whose state records two things: the last sampled bit, and whether that bit repeated the one before it.

The healthy flag is high while the two most recent samples differ. It drops as soon as two equal samples arrive in a row. Two 1s mean a gap has filled in, and two 0s mean a tooth has broken off. The flag returns high on the first sample that differs again. The two-bit state code is also driven out, so that the encoding can be checked directly.

Top module: `alt_health_mon`

## Requirements
- R1: While `rst_ni` is low, the state code is forced to 2'b00 without waiting for a clock edge, and `healthy_o` reads 1.
- R2: The state codes are fixed. One 0 seen is 2'b00. Two 1s in a row is 2'b01. Two 0s in a row is 2'b10. One 1 seen is 2'b11.
- R3: On an enabled edge, state bit 1 takes the inverse of the old state bit 0, and state bit 0 takes the sensor bit.
- R4: On an edge where `smp_en_i` is low, the state code does not change, whatever the value of `sense_i`.
- R5: `healthy_o` is a function of the state only. It is 1 for codes 2'b00 and 2'b11, and 0 for codes 2'b01 and 2'b10.
- R6: After an enabled sample equal to the previous sampled bit, `healthy_o` is 0 from the next edge. The first sample after reset is treated as following a 0.
- R7: After an enabled sample that differs from the previous sampled bit, `healthy_o` is 1 from the next edge, including straight out of either unhealthy state.
- R8: A run of equal samples keeps the machine in its repeat state: 2'b10 for 0s and 2'b01 for 1s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample enable; when high, the sensor is sampled at this edge |
| sense_i | input | 1 | Sensor bit: 1 for a tooth, 0 for a gap |
| healthy_o | output | 1 | High while the last two samples differ |
| state_o | output | 2 | Current state code |

## Verification
On every cycle, the assertions check four things: the reset value, the bit-level next-state rule, holding while disabled, and the effect of a repeated or alternating sample on the flag a cycle later. The bench adds what only whole sequences can show. It runs a model that tracks sample history and knows nothing of the state encoding. With that model it shows long repeat runs, recovery from each unhealthy state, and sensor toggling while the enable is low. It also shows a reset asserted between edges and the treatment of the first sample after reset.

// File: rtl/alt_health_pkg.sv
package alt_health_pkg;
  localparam int unsigned ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_ONE0 = 2'b00,
    ST_TWO1 = 2'b01,
    ST_TWO0 = 2'b10,
    ST_ONE1 = 2'b11
  } ah_state_e;

  localparam logic [ST_W-1:0] ST_RESET = ST_ONE0;
endpackage

// File: rtl/alt_health_nsl.sv
module alt_health_nsl
  import alt_health_pkg::*;
(
  input  logic            prev_bit_i,
  input  logic            sense_i,
  output logic [ST_W-1:0] nxt_o
);
  // bit0 remembers the sample; bit1 flags "differs from it" via inverted old bit0
  always_comb begin
    nxt_o    = '0;
    nxt_o[1] = ~prev_bit_i;
    nxt_o[0] = sense_i;
  end
endmodule

// File: rtl/alt_health_sreg.sv
module alt_health_sreg #(
  parameter int unsigned      W       = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[i] <= RST_VAL[i];
      else if (en_i) q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/alt_health_ofl.sv
module alt_health_ofl
  import alt_health_pkg::*;
(
  input  logic [ST_W-1:0] st_i,
  output logic            healthy_o
);
  always_comb healthy_o = ~(st_i[1] ^ st_i[0]);
endmodule

// File: rtl/alt_health_mon.sv
module alt_health_mon
  import alt_health_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_en_i,
  input  logic       sense_i,
  output logic       healthy_o,
  output logic [1:0] state_o
);
  logic [ST_W-1:0] st_q, st_d;

  alt_health_nsl u_nsl (
    .prev_bit_i (st_q[0]),
    .sense_i    (sense_i),
    .nxt_o      (st_d)
  );

  alt_health_sreg #(.W(ST_W), .RST_VAL(ST_RESET)) u_sreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (smp_en_i),
    .d_i    (st_d),
    .q_o    (st_q)
  );

  alt_health_ofl u_ofl (
    .st_i      (st_q),
    .healthy_o (healthy_o)
  );

  assign state_o = st_q;
endmodule

// File: rtl/alt_health_mon_chk.sv
module alt_health_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       smp_en_i,
  input logic       sense_i,
  input logic       healthy_o,
  input logic [1:0] state_o
);
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (state_o == 2'b00 && healthy_o));

  p_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_i |=> state_o == {~$past(state_o[0]), $past(sense_i)});

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_en_i |=> $stable(state_o));

  p_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    healthy_o == (state_o == 2'b00 || state_o == 2'b11));

  p_repeat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_en_i && sense_i == state_o[0]) |=> !healthy_o);

  p_alt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_en_i && sense_i != state_o[0]) |=> healthy_o);

  p_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_en_i && state_o == 2'b10 && !sense_i) |=> state_o == 2'b10);
endmodule

bind alt_health_mon alt_health_mon_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_en_i  (smp_en_i),
  .sense_i   (sense_i),
  .healthy_o (healthy_o),
  .state_o   (state_o)
);

// File: tb/alt_health_mon_bench.sv
module alt_health_mon_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       smp_en = 1'b0;
  logic       sense = 1'b0;
  logic       healthy;
  logic [1:0] state;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0] st;
    logic       h;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  logic       m_last = 1'b0;
  logic       m_h    = 1'b1;
  logic [1:0] m_st   = 2'b00;

  always #(CLK_P/2) clk = ~clk;

  alt_health_mon u_alt_health_mon (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .smp_en_i  (smp_en),
    .sense_i   (sense),
    .healthy_o (healthy),
    .state_o   (state)
  );

  task automatic check(input string tag, input logic [1:0] st_a, input logic h_a,
                       input logic [1:0] st_e, input logic h_e);
    checks++;
    if (st_a !== st_e || h_a !== h_e) begin
      errors++;
      $display("FAIL %s: state=%b healthy=%b expected state=%b healthy=%b",
               tag, st_a, h_a, st_e, h_e);
    end
  endtask

  task automatic model_reset();
    m_last = 1'b0;
    m_h    = 1'b1;
    m_st   = 2'b00;
  endtask

  // driver: apply one edge's inputs and queue the expected result
  task automatic drive(input logic en, input logic s, input string tag);
    exp_t e;
    logic rep;
    @(negedge clk);
    smp_en = en;
    sense  = s;
    if (en) begin
      rep    = (s == m_last);
      m_last = s;
      m_h    = !rep;
      // R2 codes from sample history
      if (s) m_st = rep ? 2'b01 : 2'b11;
      else   m_st = rep ? 2'b10 : 2'b00;
    end
    e.st  = m_st;
    e.h   = m_h;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare one item per edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, state, healthy, e.st, e.h);
    end
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 3);
    check("R1 reset state", state, healthy, 2'b00, 1'b1);
    check("R5 flag after reset", state, healthy, 2'b00, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();

    // alternation from reset: 1,0,1,0
    drive(1'b1, 1'b1, "R7 alt 1 -> one1 11");
    drive(1'b1, 1'b0, "R7 alt 0 -> one0 00");
    drive(1'b1, 1'b1, "R3 alt 1");
    drive(1'b1, 1'b0, "R3 alt 0");
    // repeat 0s, run of 0s, recovery
    drive(1'b1, 1'b0, "R6 repeat 0 -> two0 10");
    drive(1'b1, 1'b0, "R8 run of 0s stays 10");
    drive(1'b1, 1'b0, "R8 run of 0s stays 10");
    drive(1'b1, 1'b1, "R7 recover from two0");
    // repeat 1s, run, recovery
    drive(1'b1, 1'b1, "R6 repeat 1 -> two1 01");
    drive(1'b1, 1'b1, "R8 run of 1s stays 01");
    drive(1'b1, 1'b0, "R7 recover from two1");
    // hold with sensor toggling
    drive(1'b0, 1'b0, "R4 hold en low");
    drive(1'b0, 1'b1, "R4 hold en low");
    drive(1'b0, 1'b0, "R4 hold en low");
    drive(1'b1, 1'b0, "R6 repeat across hold");
    drive(1'b0, 1'b1, "R4 hold in two0");
    drive(1'b1, 1'b1, "R3 after hold");
    drive(1'b0, 1'b0, "R4 hold in one1");
    drive(1'b1, 1'b1, "R6 repeat 1 after hold");
    drive(1'b0, 1'b0, "R4 hold in two1");
    @(negedge clk);
    smp_en = 1'b0;
    repeat (2) @(negedge clk);

    // asynchronous reset between edges
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1 async reset mid-cycle", state, healthy, 2'b00, 1'b1);
    @(negedge clk);
    check("R1 reset held", state, healthy, 2'b00, 1'b1);
    rst_ni = 1'b1;
    model_reset();

    // first sample after reset follows an implied 0
    drive(1'b1, 1'b0, "R6 first sample 0 after reset");
    drive(1'b1, 1'b1, "R7 recover after reset");
    drive(1'b1, 1'b0, "R2 code one0");
    @(negedge clk);
    smp_en = 1'b0;
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule